// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

This block is one channel of a memory-to-memory copy engine. Software programs a source pointer, a destination pointer, a unit count and a 16-bit control halfword through strobed write ports. Software may instead use a combined 32-bit write that carries the count in its low half and the control halfword in its high half. The channel index parameter (0 to 3) sets how many address bits the pointer registers keep and how wide the count register is.

Setting the enable bit from 0 to 1 copies the programmed pointers and count into working registers. The channel then moves one unit at a time over a plain master port. Each unit is one read handshake followed by one write handshake. After each unit the working pointers step according to their address-control codes and the working count drops by one. When the count runs out, the channel clears its enable bit. If interrupts are requested, it also gives a one-cycle interrupt pulse.

Control halfword layout: bit 15 enable, bit 14 interrupt request, bit 10 unit width (1 = 32-bit, 0 = 16-bit), bits 8:7 source address code, bits 6:5 destination address code. Address codes: 0 increment, 1 decrement, 2 fixed, 3 increment-with-reload.

Top module: `dma_chan_top`

## Requirements
- R1: A source pointer write keeps the low 27 bits for channel 0 and the low 28 bits for channels 1 to 3. The upper bits read as zero in every source address the channel puts on the bus.
- R2: A destination pointer write keeps the low 27 bits for channels 0 to 2 and the low 28 bits for channel 3.
- R3: The count register is 14 bits wide for channels 0 to 2 and 16 bits wide for channel 3. A count write keeps only the low bits, and the transfer moves exactly that many units.
- R4: The working pointers and count are loaded only when control bit 15 goes from 0 to 1. A control write that leaves bit 15 at 1 does not reload them, even after new pointer or count writes.
- R5: A programmed count of zero loads the working count with all ones for its width, so 16383 units move on channels 0 to 2.
- R6: Control bit 10 = 1 moves 32-bit units with an address step of 4. Bit 10 = 0 moves the low 16 bits of the read data with a step of 2, and bits 31:16 of the write data are zero. Both bus width flags follow bit 10.
- R7: After each unit, each pointer steps by its 2-bit code: 0 adds the step, 1 subtracts it, 2 leaves the pointer unchanged. Destination code 3 adds the step.
- R8: Enabling with source code 3 makes no bus access, clears bit 15 and sets the error output. The error output then stays set until reset.
- R9: A unit is a read request whose address holds until read-valid, then a write request holding address and data until write-ready. Read and write requests are never active together.
- R10: When the last unit's write completes, bit 15 clears. If control bit 14 is set, the interrupt output is high for exactly one cycle. If bit 14 is clear, the interrupt output stays low.
- R11: A combined 32-bit write loads the count from bits 15:0 and the control from bits 31:16. The same rising-edge check on enable applies, and the new count is used for the load.
- R12: After reset, the control readback, bus requests, interrupt and error outputs are zero. The control readback returns the last halfword written, with bit 15 cleared by the channel when it finishes or fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcWrEn | input | 1 | Source pointer write strobe |
| srcWrData | input | 32 | Source pointer write value |
| dstWrEn | input | 1 | Destination pointer write strobe |
| dstWrData | input | 32 | Destination pointer write value |
| cntWrEn | input | 1 | Count write strobe |
| cntWrData | input | 16 | Count write value |
| ctlWrEn | input | 1 | Control halfword write strobe |
| ctlWrData | input | 16 | Control halfword write value |
| wordWrEn | input | 1 | Combined count and control write strobe |
| wordWrData | input | 32 | Combined write value: control in 31:16, count in 15:0 |
| ctlRdData | output | 16 | Control halfword readback |
| busRdReq | output | 1 | Read request |
| busRdAddr | output | 32 | Read address |
| busRdWide | output | 1 | Read is 32-bit when high |
| busRdValid | input | 1 | Read data valid |
| busRdData | input | 32 | Read data |
| busWrReq | output | 1 | Write request |
| busWrAddr | output | 32 | Write address |
| busWrData | output | 32 | Write data |
| busWrWide | output | 1 | Write is 32-bit when high |
| busWrReady | input | 1 | Write accepted |
| irqPulse | output | 1 | One-cycle completion interrupt |
| srcErr | output | 1 | Sticky illegal source code flag |

## Verification
The bench targets several corner cases:
- It rewrites the pointers and control while a transfer is stalled. A design that reloads on any write with enable set would restart from the new source address.
- It programs a zero count. This catches a channel that moves no units, or only one.
- It writes a count with bits set above the register width. A design that keeps those bits would move the wrong number of units.
- It enables the channel with the illegal source code. A careless design would issue bus reads or leave enable set.
- Random runs mix widths, directions and handshake delays. They expose a wrong step size, a destination code 3 treated as fixed, stale write data in 16-bit mode, or an interrupt that is missing or lasts more than one cycle.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    ADJ_INC = 2'd0,
    ADJ_DEC = 2'd1,
    ADJ_FIX = 2'd2,
    ADJ_RLD = 2'd3
  } adjCode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } chanState_e;

  // control halfword field positions
  localparam int CTL_EN_BIT   = 15;
  localparam int CTL_IRQ_BIT  = 14;
  localparam int CTL_WIDE_BIT = 10;
  localparam int CTL_SRC_LO   = 7;
  localparam int CTL_DST_LO   = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic latchData;
    logic advance;
    logic clearEn;
  } dmaStrobe_t;

  // next working pointer after one unit
  function automatic logic [31:0] stepAddr(input logic [31:0] addr,
                                           input adjCode_e code,
                                           input logic wide,
                                           input logic isSrc);
    logic [31:0] stride;
    stride = wide ? 32'd4 : 32'd2;
    unique case (code)
      ADJ_INC: stepAddr = addr + stride;
      ADJ_DEC: stepAddr = addr - stride;
      ADJ_FIX: stepAddr = addr;
      default: stepAddr = isSrc ? addr : addr + stride;
    endcase
  endfunction

endpackage

// File: rtl/dma_chan_datapath.sv
module dma_chan_datapath
  import dma_chan_pkg::*;
#(
  parameter int CHAN_ID = 0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        srcWrEn,
  input  logic [31:0] srcWrData,
  input  logic        dstWrEn,
  input  logic [31:0] dstWrData,
  input  logic        cntWrEn,
  input  logic [15:0] cntWrData,
  input  logic        ctlWrEn,
  input  logic [15:0] ctlWrData,
  input  logic        wordWrEn,
  input  logic [31:0] wordWrData,
  input  logic [31:0] rdData,
  input  dmaStrobe_t  strobe,
  output logic [15:0] ctlOut,
  output logic [31:0] workSrc,
  output logic [31:0] workDst,
  output logic [31:0] wrData,
  output logic        chanEn,
  output logic        irqEn,
  output logic        wideMode,
  output adjCode_e    srcCode,
  output adjCode_e    dstCode,
  output logic        lastUnit
);

  localparam int SRC_BITS = (CHAN_ID == 0) ? 27 : 28;
  localparam int DST_BITS = (CHAN_ID == 3) ? 28 : 27;
  localparam int CNT_W    = (CHAN_ID == 3) ? 16 : 14;
  localparam logic [31:0] SRC_MASK = (32'd1 << SRC_BITS) - 32'd1;
  localparam logic [31:0] DST_MASK = (32'd1 << DST_BITS) - 32'd1;

  logic [31:0]      srcReg, dstReg;
  logic [CNT_W-1:0] cntReg, workCnt;
  logic [15:0]      ctlReg;

  // write path decode: the combined write wins over the halfword ports
  logic             ctlWrite, cntWrite, loadWork;
  logic [15:0]      ctlNew, cntSrc;
  logic [CNT_W-1:0] cntNew, cntForLoad;

  always_comb begin
    ctlWrite   = ctlWrEn | wordWrEn;
    cntWrite   = cntWrEn | wordWrEn;
    ctlNew     = wordWrEn ? wordWrData[31:16] : ctlWrData;
    cntSrc     = wordWrEn ? wordWrData[15:0]  : cntWrData;
    cntNew     = CNT_W'(cntSrc);
    cntForLoad = cntWrite ? cntNew : cntReg;
    loadWork   = ctlWrite & ~ctlReg[CTL_EN_BIT] & ctlNew[CTL_EN_BIT];
  end

  // programmed registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcReg <= '0;
      dstReg <= '0;
      cntReg <= '0;
      ctlReg <= '0;
    end else begin
      if (srcWrEn)  srcReg <= srcWrData & SRC_MASK;
      if (dstWrEn)  dstReg <= dstWrData & DST_MASK;
      if (cntWrite) cntReg <= cntNew;
      if (ctlWrite)            ctlReg <= ctlNew;
      else if (strobe.clearEn) ctlReg[CTL_EN_BIT] <= 1'b0;
    end
  end

  // working registers: loaded on the enable rising edge only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workSrc <= '0;
      workDst <= '0;
      workCnt <= '0;
    end else if (loadWork) begin
      workSrc <= srcReg;
      workDst <= dstReg;
      workCnt <= (cntForLoad == '0) ? '1 : cntForLoad;
    end else if (strobe.advance) begin
      workSrc <= stepAddr(workSrc, srcCode, wideMode, 1'b1);
      workDst <= stepAddr(workDst, dstCode, wideMode, 1'b0);
      workCnt <= workCnt - 1'b1;
    end
  end

  // unit buffer between read and write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 wrData <= '0;
    else if (strobe.latchData) wrData <= wideMode ? rdData : {16'h0000, rdData[15:0]};
  end

  assign ctlOut   = ctlReg;
  assign chanEn   = ctlReg[CTL_EN_BIT];
  assign irqEn    = ctlReg[CTL_IRQ_BIT];
  assign wideMode = ctlReg[CTL_WIDE_BIT];
  assign srcCode  = adjCode_e'(ctlReg[CTL_SRC_LO +: 2]);
  assign dstCode  = adjCode_e'(ctlReg[CTL_DST_LO +: 2]);
  assign lastUnit = (workCnt == CNT_W'(1));

  AST_LOAD_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    loadWork |=> workCnt != '0); // R5
  AST_LOAD_SRC_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    loadWork |=> (workSrc & ~SRC_MASK) == 32'd0); // R1
  AST_LOAD_DST_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    loadWork |=> (workDst & ~DST_MASK) == 32'd0); // R2

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       chanEn,
  input  logic       irqEn,
  input  adjCode_e   srcCode,
  input  logic       lastUnit,
  input  logic       busRdValid,
  input  logic       busWrReady,
  output dmaStrobe_t strobe,
  output logic       busRdReq,
  output logic       busWrReq,
  output logic       irqPulse,
  output logic       errFlag
);

  chanState_e state, stateNxt;
  logic       setErr;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    setErr   = 1'b0;
    busRdReq = 1'b0;
    busWrReq = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (chanEn) begin
          if (srcCode == ADJ_RLD) begin
            setErr         = 1'b1;
            strobe.clearEn = 1'b1;
          end else begin
            stateNxt = ST_READ;
          end
        end
      end
      ST_READ: begin
        busRdReq = 1'b1;
        if (busRdValid) begin
          strobe.latchData = 1'b1;
          stateNxt         = ST_WRITE;
        end
      end
      ST_WRITE: begin
        busWrReq = 1'b1;
        if (busWrReady) begin
          strobe.advance = 1'b1;
          strobe.clearEn = lastUnit;
          stateNxt       = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      irqPulse <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      state    <= stateNxt;
      irqPulse <= strobe.advance & lastUnit & irqEn;
      errFlag  <= errFlag | setErr;
    end
  end

  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(busRdReq && busWrReq)); // R9
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R8
  AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> !busRdReq && !busWrReq); // R8

endmodule

// File: rtl/dma_chan_top.sv
module dma_chan_top
  import dma_chan_pkg::*;
#(
  parameter int CHAN_ID = 0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        srcWrEn,
  input  logic [31:0] srcWrData,
  input  logic        dstWrEn,
  input  logic [31:0] dstWrData,
  input  logic        cntWrEn,
  input  logic [15:0] cntWrData,
  input  logic        ctlWrEn,
  input  logic [15:0] ctlWrData,
  input  logic        wordWrEn,
  input  logic [31:0] wordWrData,
  output logic [15:0] ctlRdData,
  output logic        busRdReq,
  output logic [31:0] busRdAddr,
  output logic        busRdWide,
  input  logic        busRdValid,
  input  logic [31:0] busRdData,
  output logic        busWrReq,
  output logic [31:0] busWrAddr,
  output logic [31:0] busWrData,
  output logic        busWrWide,
  input  logic        busWrReady,
  output logic        irqPulse,
  output logic        srcErr
);

  dmaStrobe_t strobe;
  logic       chanEn, irqEn, wideMode, lastUnit;
  adjCode_e   srcCode, dstCode;

  dma_chan_datapath #(.CHAN_ID(CHAN_ID)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .srcWrEn    (srcWrEn),
    .srcWrData  (srcWrData),
    .dstWrEn    (dstWrEn),
    .dstWrData  (dstWrData),
    .cntWrEn    (cntWrEn),
    .cntWrData  (cntWrData),
    .ctlWrEn    (ctlWrEn),
    .ctlWrData  (ctlWrData),
    .wordWrEn   (wordWrEn),
    .wordWrData (wordWrData),
    .rdData     (busRdData),
    .strobe     (strobe),
    .ctlOut     (ctlRdData),
    .workSrc    (busRdAddr),
    .workDst    (busWrAddr),
    .wrData     (busWrData),
    .chanEn     (chanEn),
    .irqEn      (irqEn),
    .wideMode   (wideMode),
    .srcCode    (srcCode),
    .dstCode    (dstCode),
    .lastUnit   (lastUnit)
  );

  dma_chan_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .chanEn     (chanEn),
    .irqEn      (irqEn),
    .srcCode    (srcCode),
    .lastUnit   (lastUnit),
    .busRdValid (busRdValid),
    .busWrReady (busWrReady),
    .strobe     (strobe),
    .busRdReq   (busRdReq),
    .busWrReq   (busWrReq),
    .irqPulse   (irqPulse),
    .errFlag    (srcErr)
  );

  assign busRdWide = wideMode;
  assign busWrWide = wideMode;

  AST_RD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busRdReq && !busRdValid && !ctlWrEn && !wordWrEn |=> $stable(busRdAddr)); // R9
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busWrReq && !busWrReady && !ctlWrEn && !wordWrEn
      |=> $stable(busWrAddr) && $stable(busWrData)); // R9

endmodule

// File: tb/dma_chan_top_tb.sv
`timescale 1ns/1ps
module dma_chan_top_tb;

  localparam int CH = 0;
  localparam logic [31:0] SRC_MASK = (CH == 0) ? 32'h07FF_FFFF : 32'h0FFF_FFFF;
  localparam logic [31:0] DST_MASK = (CH == 3) ? 32'h0FFF_FFFF : 32'h07FF_FFFF;
  localparam logic [15:0] CNT_MASK = (CH == 3) ? 16'hFFFF : 16'h3FFF;
  localparam logic [15:0] EN = 16'h8000, IRQ = 16'h4000, WIDE = 16'h0400;

  logic clk = 1'b0, rstN = 1'b0;
  logic srcWrEn = 0, dstWrEn = 0, cntWrEn = 0, ctlWrEn = 0, wordWrEn = 0;
  logic [31:0] srcWrData = 0, dstWrData = 0, wordWrData = 0;
  logic [15:0] cntWrData = 0, ctlWrData = 0;
  logic [15:0] ctlRdData;
  logic busRdReq, busRdWide, busWrReq, busWrWide, irqPulse, srcErr;
  logic busRdValid = 0, busWrReady = 0;
  logic [31:0] busRdAddr, busRdData = 0, busWrAddr, busWrData;

  int total = 0, bad = 0;
  bit hold = 0, fast = 0;
  logic [31:0] expSrc, expDst;
  logic [1:0]  sCode, dCode;
  logic        expWide;
  int unitCount = 0, mism = 0, irqCount = 0, rdSeen = 0, holdErr = 0, orderErr = 0;
  bit rdDone = 0;

  always #2 clk = ~clk;

  dma_chan_top #(.CHAN_ID(CH)) u_dut (
    .clk(clk), .rstN(rstN),
    .srcWrEn(srcWrEn), .srcWrData(srcWrData), .dstWrEn(dstWrEn), .dstWrData(dstWrData),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .wordWrEn(wordWrEn), .wordWrData(wordWrData), .ctlRdData(ctlRdData),
    .busRdReq(busRdReq), .busRdAddr(busRdAddr), .busRdWide(busRdWide),
    .busRdValid(busRdValid), .busRdData(busRdData), .busWrReq(busWrReq),
    .busWrAddr(busWrAddr), .busWrData(busWrData), .busWrWide(busWrWide),
    .busWrReady(busWrReady), .irqPulse(irqPulse), .srcErr(srcErr)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_C3C3;
  endfunction

  function automatic logic [31:0] nextAddr(input logic [31:0] a, input logic [1:0] code,
                                           input logic wide, input logic isSrc);
    logic [31:0] st;
    st = wide ? 32'd4 : 32'd2;
    case (code)
      2'd0: return a + st;
      2'd1: return a - st;
      2'd2: return a;
      default: return isSrc ? a : a + st;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bus responder and write monitor, all at the falling edge
  initial begin
    logic [31:0] lastAddr;
    logic        lastWait;
    logic [31:0] ed;
    lastWait = 0;
    lastAddr = 0;
    forever begin
      @(negedge clk);
      if (lastWait && busRdReq && busRdAddr !== lastAddr) holdErr++;
      busRdValid = busRdReq && !hold && (fast || ($urandom % 3 != 0));
      busRdData  = memWord(busRdAddr);
      lastWait   = busRdReq && !busRdValid;
      lastAddr   = busRdAddr;
      if (busRdReq) rdSeen++;
      if (busRdReq && busRdValid) rdDone = 1;
      busWrReady = busWrReq && !hold && (fast || ($urandom % 3 != 0));
      if (busWrReq && busWrReady) begin
        if (!rdDone) orderErr++;
        rdDone = 0;
        ed = expWide ? memWord(expSrc) : {16'h0000, memWord(expSrc)[15:0]};
        if (busWrAddr !== expDst || busWrData !== ed || busWrWide !== expWide || busRdWide !== expWide)
          mism++;
        expSrc = nextAddr(expSrc, sCode, expWide, 1'b1);
        expDst = nextAddr(expDst, dCode, expWide, 1'b0);
        unitCount++;
      end
      if (irqPulse) irqCount++;
    end
  end

  task automatic pulseWrite(input int which, input logic [31:0] v);
    @(negedge clk);
    case (which)
      0: begin srcWrEn = 1; srcWrData = v; end
      1: begin dstWrEn = 1; dstWrData = v; end
      2: begin cntWrEn = 1; cntWrData = v[15:0]; end
      3: begin ctlWrEn = 1; ctlWrData = v[15:0]; end
      default: begin wordWrEn = 1; wordWrData = v; end
    endcase
    @(negedge clk);
    srcWrEn = 0; dstWrEn = 0; cntWrEn = 0; ctlWrEn = 0; wordWrEn = 0;
  endtask

  int expUnits;
  logic [15:0] lastCtl;

  task automatic startXfer(input logic [31:0] s, input logic [31:0] d, input logic [15:0] c,
                           input logic [15:0] ctl, input bit useWord);
    logic [15:0] cm;
    expSrc  = s & SRC_MASK;
    expDst  = d & DST_MASK;
    cm      = c & CNT_MASK;
    expUnits = (cm == 0) ? int'(CNT_MASK) : int'(cm);
    sCode   = ctl[8:7];
    dCode   = ctl[6:5];
    expWide = ctl[10];
    lastCtl = ctl;
    unitCount = 0; mism = 0; irqCount = 0;
    pulseWrite(0, s);
    pulseWrite(1, d);
    if (useWord) pulseWrite(4, {ctl, c});
    else begin
      pulseWrite(2, {16'h0, c});
      pulseWrite(3, {16'h0, ctl});
    end
  endtask

  task automatic finishXfer(input string req);
    int guard;
    guard = 0;
    while (ctlRdData[15] && guard < 100000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    check({req, " unit data and addresses"}, mism, 0);
    check({req, " unit count"}, unitCount, expUnits);
    check({req, " R10 irq pulses"}, irqCount, lastCtl[14] ? 1 : 0);
    check({req, " R12 ctl readback enable cleared"}, ctlRdData, lastCtl & ~EN);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 reset ctl", ctlRdData, 16'h0);
    check("R12 reset rdReq", busRdReq, 0);
    check("R12 reset wrReq", busWrReq, 0);
    check("R12 reset irq", irqPulse, 0);
    check("R12 reset err", srcErr, 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R1 R2 R6 R7 R10: wide, both increment, irq, upper address bits dropped
    startXfer(32'hFFFF_FFF0, 32'hFFFF_FF00, 16'd4, EN | IRQ | WIDE | (2'd0 << 7) | (2'd0 << 5), 0);
    finishXfer("R1 R2 R6 R7");

    // R6 R7: narrow, source decrement, destination fixed, no irq
    startXfer(32'h0000_1000, 32'h0000_2000, 16'd5, EN | (2'd1 << 7) | (2'd2 << 5), 0);
    finishXfer("R6 R7 narrow dec fixed");

    // R7: destination code 3 steps like increment, source fixed
    startXfer(32'h0000_3000, 32'h0000_4000, 16'd3, EN | IRQ | WIDE | (2'd2 << 7) | (2'd3 << 5), 0);
    finishXfer("R7 dst code3");

    // R3: bits above the count width are dropped
    startXfer(32'h0000_5000, 32'h0000_6000, 16'h4002, EN | IRQ | (2'd0 << 7) | (2'd1 << 5), 0);
    finishXfer("R3 count truncation");

    // R11: combined write of count and control
    startXfer(32'h0000_7000, 32'h0000_8000, 16'd6, EN | IRQ | WIDE | (2'd1 << 7) | (2'd0 << 5), 1);
    finishXfer("R11 combined write");

    // R4: rewrites while enabled do not reload the working registers
    hold = 1;
    startXfer(32'h0000_9000, 32'h0000_A000, 16'd3, EN | WIDE, 0);
    repeat (4) @(negedge clk);
    check("R4 read address before rewrite", busRdAddr, 32'h0000_9000);
    pulseWrite(0, 32'h0000_BB00);
    pulseWrite(2, 32'd9);
    pulseWrite(3, {16'h0, EN | WIDE});
    @(negedge clk);
    check("R4 read address after rewrite", busRdAddr, 32'h0000_9000);
    hold = 0;
    finishXfer("R4 no reload");

    // R9: handshake order and address hold across stalls so far
    check("R9 read address held while waiting", holdErr, 0);
    check("R9 each write preceded by a read", orderErr, 0);

    // random transfers
    for (int i = 0; i < 10; i++) begin
      logic [15:0] ctl;
      ctl = EN | ($urandom % 2 ? IRQ : 16'h0) | ($urandom % 2 ? WIDE : 16'h0)
            | 16'(($urandom % 3) << 7) | 16'(($urandom % 4) << 5);
      startXfer($urandom, $urandom, 16'(1 + $urandom % 12), ctl, bit'($urandom % 2));
      finishXfer("R7 random");
    end
    check("R9 random hold", holdErr, 0);
    check("R9 random order", orderErr, 0);

    // R5: zero count moves the maximum number of units
    fast = 1;
    startXfer(32'h0000_0100, 32'h0000_0200, 16'd0, EN | IRQ | (2'd2 << 7) | (2'd2 << 5), 0);
    finishXfer("R5 zero count");
    fast = 0;

    // R8: illegal source code
    rdSeen = 0;
    lastCtl = EN | IRQ | (2'd3 << 7);
    irqCount = 0;
    pulseWrite(3, {16'h0, lastCtl});
    repeat (5) @(negedge clk);
    check("R8 no bus reads", rdSeen, 0);
    check("R8 error set", srcErr, 1);
    check("R8 enable cleared", ctlRdData, lastCtl & ~EN);
    check("R8 no irq", irqCount, 0);
    startXfer(32'h0000_0400, 32'h0000_0800, 16'd2, EN | WIDE, 0);
    finishXfer("R8 after error");
    check("R8 error sticky", srcErr, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule